// File: doc/BRIEF.md
# Dual-Issue Pair Checker

This block sits between instruction fetch and two execution pipes of an in-order core. Each cycle it looks at a 64-bit fetch packet carrying two 32-bit instructions and works out which of them may issue. One pipe runs arithmetic and branch work. The other pipe runs loads and stores. The lower word of the packet is the older instruction and the upper word is the younger one.

The block decodes each word's class and register fields. Both words issue together only when they need different pipes and the younger one does not depend on the older one. When they cannot go together, the older word issues and the younger word is held. The held word is presented again, on its own, in the next cycle. The block also enforces the one-slot load-use delay against the load that issued in the previous cycle. It routes each issued word to its pipe and drives four register read addresses, two per pipe.

Issue decisions are registered, so they appear at the outputs one clock edge after the packet is presented. The `pkt_ready` output tells fetch whether the current packet is consumed in this cycle.

Top module: `dip_pair_checker`

## Requirements
- R1: While reset is asserted, and until the first packet is presented after release, `alu_go`, `mem_go`, `pair_split` and `hazard_stall` are low, all words and read addresses are zero, and `pkt_ready` is high.
- R2: Opcode field bits [31:26] select the class. 0x00 (R-type: reads rs [25:21] and rt [20:16], writes rd [15:11]) and 0x08 (immediate add: reads rs, writes rt) are arithmetic. 0x04 and 0x05 (reads rs and rt) are branches. Arithmetic and branch words issue only on the ALU pipe. 0x23 (load: reads rs, writes rt) and 0x2B (store: reads rs and rt) issue only on the memory pipe.
- R3: Both words issue in the same cycle when they need different pipes, the younger reads no register the older writes (RAW), and the two do not write the same register (WAW). Register 0 never creates a dependency, whether it is a source or a destination.
- R4: If both words need the same pipe, or there is a RAW or WAW conflict, only the older word issues and `pair_split` is raised. The younger word issues alone in the following cycle unless it is stalled. `pkt_ready` is low while a word is held.
- R5: If the previous cycle issued a load with a nonzero destination, and the oldest non-empty candidate reads that register, nothing issues, `hazard_stall` is raised and the packet is not consumed. If only the younger word reads it, the pair is split as in R4.
- R6: The all-zero word, any opcode not listed in R2, and either word while `pkt_valid` is low are empty slots. An empty slot issues nothing and never blocks the other word.
- R7: The read-address outputs of each pipe carry the source registers of the word issued on that pipe, with zero for an unused source and zero for an idle pipe.
- R8: A branch may be paired with a load or store in the same cycle; the memory word then acts as the branch's delay slot.
- R9: The issue outputs for a packet change only at the rising clock edge that follows its presentation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized inside for release |
| pkt_valid | input | 1 | Fetch packet is present |
| pkt | input | 64 | Older word in [31:0], younger word in [63:32] |
| pkt_ready | output | 1 | Packet is consumed in this cycle |
| alu_go | output | 1 | ALU/branch pipe receives a word |
| alu_word | output | 32 | Word issued to the ALU/branch pipe |
| mem_go | output | 1 | Load/store pipe receives a word |
| mem_word | output | 32 | Word issued to the load/store pipe |
| pair_split | output | 1 | Younger word was held back this cycle |
| hazard_stall | output | 1 | Load-use delay blocked issue this cycle |
| rp_alu_a | output | 5 | First read address for the ALU pipe |
| rp_alu_b | output | 5 | Second read address for the ALU pipe |
| rp_mem_a | output | 5 | First read address for the memory pipe |
| rp_mem_b | output | 5 | Second read address for the memory pipe |

## Verification
A corrupt held word shows up one cycle after a split. In that cycle the re-issued word or its pipe differs from the packet's upper half, and `pkt_ready` stays low for the wrong number of cycles. A stale or missing load-destination record shows up in the very next cycle as an extra or missing `hazard_stall` on a dependent word. Because the sweep runs all class pairs with small register indices that include zero, every dependency shape is visited, and each one is compared on every cycle.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned OPC_LSB = 26;
  localparam int unsigned RS_LSB  = 21;
  localparam int unsigned RT_LSB  = 16;
  localparam int unsigned RD_LSB  = 11;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  typedef enum logic [2:0] {CL_NONE, CL_ALU, CL_BR, CL_LD, CL_ST} cls_e;

  typedef struct packed {
    cls_e             cls;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] dst;
  } dec_t;

  function automatic logic on_mem(input cls_e c);
    return (c == CL_LD) || (c == CL_ST);
  endfunction

  function automatic logic reads_reg(input dec_t d, input logic [REG_W-1:0] r);
    return (r != '0) && ((d.src_a == r) || (d.src_b == r));
  endfunction
endpackage

// File: rtl/dip_rst_sync.sv
module dip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dip_decode.sv
module dip_decode
  import dip_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  logic [5:0]       opc;
  logic [REG_W-1:0] f_rs, f_rt, f_rd;

  assign opc  = word[OPC_LSB +: 6];
  assign f_rs = word[RS_LSB +: REG_W];
  assign f_rt = word[RT_LSB +: REG_W];
  assign f_rd = word[RD_LSB +: REG_W];

  always_comb begin
    dec = '0;
    if (word != '0) begin
      case (opc)
        OP_RTYPE: begin dec.cls = CL_ALU; dec.src_a = f_rs; dec.src_b = f_rt; dec.dst = f_rd; end
        OP_ADDI:  begin dec.cls = CL_ALU; dec.src_a = f_rs; dec.dst = f_rt; end
        OP_BEQ,
        OP_BNE:   begin dec.cls = CL_BR;  dec.src_a = f_rs; dec.src_b = f_rt; end
        OP_LW:    begin dec.cls = CL_LD;  dec.src_a = f_rs; dec.dst = f_rt; end
        OP_SW:    begin dec.cls = CL_ST;  dec.src_a = f_rs; dec.src_b = f_rt; end
        default:  dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/dip_hazard.sv
module dip_hazard
  import dip_pkg::*;
(
  input  dec_t             old_d,
  input  dec_t             yng_d,
  input  logic             ll_vld,
  input  logic [REG_W-1:0] ll_dst,
  output logic             stall,
  output logic             go_old,
  output logic             go_yng,
  output logic             split
);
  logic e_old, e_yng, lu_old, lu_yng;
  logic same_pipe, raw, waw, conflict;

  always_comb begin
    e_old     = (old_d.cls == CL_NONE);
    e_yng     = (yng_d.cls == CL_NONE);
    lu_old    = ll_vld && !e_old && reads_reg(old_d, ll_dst);
    lu_yng    = ll_vld && !e_yng && reads_reg(yng_d, ll_dst);
    same_pipe = (on_mem(old_d.cls) == on_mem(yng_d.cls));
    raw       = (old_d.dst != '0) && reads_reg(yng_d, old_d.dst);
    waw       = (old_d.dst != '0) && (old_d.dst == yng_d.dst);
    conflict  = same_pipe || raw || waw || lu_yng;
    stall     = e_old ? (!e_yng && lu_yng) : lu_old;
    go_old    = !e_old && !stall;
    go_yng    = !e_yng && !stall && (e_old || !conflict);
    split     = !e_old && !e_yng && !stall && conflict;
  end
endmodule

// File: rtl/dip_pair_checker.sv
module dip_pair_checker
  import dip_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned PKT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [PKT_W-1:0]  pkt,
  output logic              pkt_ready,
  output logic              alu_go,
  output logic [WORD_W-1:0] alu_word,
  output logic              mem_go,
  output logic [WORD_W-1:0] mem_word,
  output logic              pair_split,
  output logic              hazard_stall,
  output logic [REG_W-1:0]  rp_alu_a,
  output logic [REG_W-1:0]  rp_alu_b,
  output logic [REG_W-1:0]  rp_mem_a,
  output logic [REG_W-1:0]  rp_mem_b
);
  logic rst_i_n;
  dip_rst_sync #(.STAGES(RST_STAGES)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  // held younger word and last issued load destination
  logic              held_vld_q, held_vld_n;
  logic [WORD_W-1:0] held_q, held_n;
  logic              ll_vld_q, ll_vld_n;
  logic [REG_W-1:0]  ll_dst_q, ll_dst_n;

  logic [WORD_W-1:0] slot_w [2];
  dec_t              slot_d [2];
  logic              go [2];
  logic              stall, split;

  always_comb begin
    slot_w[0] = held_vld_q ? held_q : (pkt_valid ? pkt[WORD_W-1:0] : '0);
    slot_w[1] = (held_vld_q || !pkt_valid) ? '0 : pkt[PKT_W-1:WORD_W];
  end

  for (genvar g = 0; g < 2; g++) begin : g_dec
    dip_decode u_dec (.word(slot_w[g]), .dec(slot_d[g]));
  end

  dip_hazard u_haz (
    .old_d(slot_d[0]), .yng_d(slot_d[1]), .ll_vld(ll_vld_q), .ll_dst(ll_dst_q),
    .stall(stall), .go_old(go[0]), .go_yng(go[1]), .split(split)
  );

  assign pkt_ready = !held_vld_q && !stall;

  // route issued words to pipes
  logic              alu_go_n, mem_go_n;
  logic [WORD_W-1:0] alu_w_n, mem_w_n;
  dec_t              alu_d_n, mem_d_n;

  always_comb begin
    alu_go_n = 1'b0; alu_w_n = '0; alu_d_n = '0;
    mem_go_n = 1'b0; mem_w_n = '0; mem_d_n = '0;
    for (int s = 0; s < 2; s++) begin
      if (go[s]) begin
        if (on_mem(slot_d[s].cls)) begin
          mem_go_n = 1'b1; mem_w_n = slot_w[s]; mem_d_n = slot_d[s];
        end else begin
          alu_go_n = 1'b1; alu_w_n = slot_w[s]; alu_d_n = slot_d[s];
        end
      end
    end
  end

  always_comb begin
    held_vld_n = held_vld_q;
    held_n     = held_q;
    if (!stall) held_vld_n = split;
    if (split)  held_n     = slot_w[1];
    ll_vld_n = (mem_d_n.cls == CL_LD) && (mem_d_n.dst != '0);
    ll_dst_n = ll_vld_n ? mem_d_n.dst : '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      held_vld_q <= 1'b0; held_q <= '0;
      ll_vld_q <= 1'b0;   ll_dst_q <= '0;
      alu_go <= 1'b0; alu_word <= '0; mem_go <= 1'b0; mem_word <= '0;
      pair_split <= 1'b0; hazard_stall <= 1'b0;
      rp_alu_a <= '0; rp_alu_b <= '0; rp_mem_a <= '0; rp_mem_b <= '0;
    end else begin
      held_vld_q <= held_vld_n; held_q <= held_n;
      ll_vld_q <= ll_vld_n;     ll_dst_q <= ll_dst_n;
      alu_go <= alu_go_n; alu_word <= alu_w_n;
      mem_go <= mem_go_n; mem_word <= mem_w_n;
      pair_split <= split; hazard_stall <= stall;
      rp_alu_a <= alu_d_n.src_a; rp_alu_b <= alu_d_n.src_b;
      rp_mem_a <= mem_d_n.src_a; rp_mem_b <= mem_d_n.src_b;
    end
  end
endmodule

// File: rtl/dip_pair_checker_sva.sv
module dip_pair_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        pkt_ready,
  input logic        alu_go,
  input logic [31:0] alu_word,
  input logic        mem_go,
  input logic [31:0] mem_word,
  input logic        pair_split,
  input logic        hazard_stall
);
  function automatic logic [4:0] wdst(input logic [31:0] w);
    case (w[31:26])
      6'h00:        return w[15:11];
      6'h08, 6'h23: return w[20:16];
      default:      return 5'd0;
    endcase
  endfunction

  function automatic logic wreads(input logic [31:0] w, input logic [4:0] r);
    logic two;
    two = (w[31:26] == 6'h00) || (w[31:26] == 6'h04) || (w[31:26] == 6'h05) || (w[31:26] == 6'h2B);
    return (r != 5'd0) && ((w[25:21] == r) || (two && (w[20:16] == r)));
  endfunction

  assert_mem_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_go |-> (mem_word[31:26] == 6'h23 || mem_word[31:26] == 6'h2B));

  assert_alu_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alu_go |-> (alu_word[31:26] == 6'h00 || alu_word[31:26] == 6'h08 ||
                alu_word[31:26] == 6'h04 || alu_word[31:26] == 6'h05));

  assert_dual_no_waw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_go && mem_go && wdst(alu_word) != 5'd0) |-> (wdst(alu_word) != wdst(mem_word)));

  assert_split_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_split |-> ($countones({alu_go, mem_go}) == 1 && !pkt_ready));

  assert_stall_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_stall |-> (!alu_go && !mem_go && !pair_split));

  assert_load_use_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_go && mem_word[31:26] == 6'h23) |=>
      !(alu_go && wreads(alu_word, $past(mem_word[20:16]))) &&
      !(mem_go && wreads(mem_word, $past(mem_word[20:16]))));
endmodule

bind dip_pair_checker dip_pair_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .pkt_ready(pkt_ready),
  .alu_go(alu_go), .alu_word(alu_word), .mem_go(mem_go), .mem_word(mem_word),
  .pair_split(pair_split), .hazard_stall(hazard_stall)
);

// File: tb/dip_pair_checker_test.sv
`timescale 1ns/1ps
module dip_pair_checker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_valid;
  logic [63:0] pkt;
  logic        pkt_ready, alu_go, mem_go, pair_split, hazard_stall;
  logic [31:0] alu_word, mem_word;
  logic [4:0]  rp_alu_a, rp_alu_b, rp_mem_a, rp_mem_b;

  always #2.5 clk = ~clk;

  dip_pair_checker uut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt(pkt), .pkt_ready(pkt_ready),
    .alu_go(alu_go), .alu_word(alu_word), .mem_go(mem_go), .mem_word(mem_word),
    .pair_split(pair_split), .hazard_stall(hazard_stall),
    .rp_alu_a(rp_alu_a), .rp_alu_b(rp_alu_b), .rp_mem_a(rp_mem_a), .rp_mem_b(rp_mem_b)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // bench model: class 0 empty, 1 arith, 2 branch, 3 load, 4 store
  function automatic int cls_of(input logic [31:0] w);
    if (w == 32'd0) return 0;
    case (w[31:26])
      6'h00, 6'h08: return 1;
      6'h04, 6'h05: return 2;
      6'h23:        return 3;
      6'h2B:        return 4;
      default:      return 0;
    endcase
  endfunction
  function automatic logic [4:0] sa_of(input logic [31:0] w);
    return (cls_of(w) != 0) ? w[25:21] : 5'd0;
  endfunction
  function automatic logic [4:0] sb_of(input logic [31:0] w);
    int c = cls_of(w);
    return ((c == 1 && w[31:26] == 6'h00) || c == 2 || c == 4) ? w[20:16] : 5'd0;
  endfunction
  function automatic logic [4:0] dst_of(input logic [31:0] w);
    int c = cls_of(w);
    if (c == 1) return (w[31:26] == 6'h00) ? w[15:11] : w[20:16];
    if (c == 3) return w[20:16];
    return 5'd0;
  endfunction
  function automatic logic rd_hit(input logic [31:0] w, input logic [4:0] r);
    return (r != 5'd0) && (sa_of(w) == r || sb_of(w) == r);
  endfunction

  function automatic logic [31:0] mk(input int c, input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd);
    case (c)
      1: return {6'h00, rs, rt, rd, 5'd0, 6'h20};
      2: return {6'h08, rs, rt, 16'h0005};
      3: return {6'h05, rs, rt, 16'h0003};
      4: return {6'h23, rs, rt, 16'h0010};
      5: return {6'h2B, rs, rt, 16'h0010};
      6: return {6'h3F, rs, rt, 16'h0001};
      default: return 32'd0;
    endcase
  endfunction

  logic        m_hv, m_llv;
  logic [31:0] m_held;
  logic [4:0]  m_lld;
  logic        prev_alu_go;

  task automatic step(input logic v, input logic [63:0] p, output logic took);
    logic [31:0] w0, w1, aw, mw;
    logic e0, e1, lu0, lu1, conf, st, g0, g1, sp, ag, mg, rdy;
    string tag;
    pkt_valid = v; pkt = p;
    #1;
    w0 = m_hv ? m_held : (v ? p[31:0] : 32'd0);
    w1 = (m_hv || !v) ? 32'd0 : p[63:32];
    e0 = (cls_of(w0) == 0); e1 = (cls_of(w1) == 0);
    lu0 = m_llv && !e0 && rd_hit(w0, m_lld);
    lu1 = m_llv && !e1 && rd_hit(w1, m_lld);
    conf = ((cls_of(w0) >= 3) == (cls_of(w1) >= 3)) ||
           (dst_of(w0) != 0 && rd_hit(w1, dst_of(w0))) ||
           (dst_of(w0) != 0 && dst_of(w0) == dst_of(w1)) || lu1;
    st = e0 ? (!e1 && lu1) : lu0;
    g0 = !e0 && !st;
    g1 = !e1 && !st && (e0 || !conf);
    sp = !e0 && !e1 && !st && conf;
    rdy = !m_hv && !st;
    ag = 0; mg = 0; aw = 0; mw = 0;
    if (g0) begin if (cls_of(w0) >= 3) begin mg = 1; mw = w0; end else begin ag = 1; aw = w0; end end
    if (g1) begin if (cls_of(w1) >= 3) begin mg = 1; mw = w1; end else begin ag = 1; aw = w1; end end
    if (ag && mg && (cls_of(aw) == 2)) tag = "R8 branch+delay-slot pair";
    else if (e0 || e1)                 tag = "R6 empty slot";
    else                               tag = "R3 pair issue";
    chk(st ? "R5 ready during stall" : "R4 ready", {31'd0, pkt_ready}, {31'd0, rdy});
    chk("R9 output before edge", {31'd0, alu_go}, {31'd0, prev_alu_go});
    @(posedge clk); #1;
    chk({tag, " alu_go"}, {31'd0, alu_go}, {31'd0, ag});
    chk("R2 alu_word", alu_word, aw);
    chk({tag, " mem_go"}, {31'd0, mem_go}, {31'd0, mg});
    chk("R2 mem_word", mem_word, mw);
    chk("R4 split", {31'd0, pair_split}, {31'd0, sp});
    chk("R5 stall", {31'd0, hazard_stall}, {31'd0, st});
    chk("R7 rp_alu_a", {27'd0, rp_alu_a}, {27'd0, sa_of(aw)});
    chk("R7 rp_alu_b", {27'd0, rp_alu_b}, {27'd0, sb_of(aw)});
    chk("R7 rp_mem_a", {27'd0, rp_mem_a}, {27'd0, sa_of(mw)});
    chk("R7 rp_mem_b", {27'd0, rp_mem_b}, {27'd0, sb_of(mw)});
    prev_alu_go = ag;
    if (!st) begin m_hv = sp; if (sp) m_held = w1; end
    m_llv = mg && (cls_of(mw) == 3) && (dst_of(mw) != 0);
    m_lld = m_llv ? dst_of(mw) : 5'd0;
    took = rdy;
    @(negedge clk);
  endtask

  initial begin
    logic took;
    rst_n = 1'b0; pkt_valid = 1'b0; pkt = '0;
    m_hv = 0; m_llv = 0; m_held = 0; m_lld = 0; prev_alu_go = 0;
    repeat (3) @(negedge clk);
    chk("R1 alu_go in reset", {31'd0, alu_go}, 32'd0);
    chk("R1 mem_go in reset", {31'd0, mem_go}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready", {31'd0, pkt_ready}, 32'd1);
    chk("R1 split", {31'd0, pair_split}, 32'd0);
    chk("R1 stall", {31'd0, hazard_stall}, 32'd0);
    chk("R1 words", alu_word | mem_word, 32'd0);
    chk("R1 read addrs", {12'd0, rp_alu_a, rp_alu_b, rp_mem_a, rp_mem_b}, 32'd0);
    for (int a = 0; a < 7; a++) begin
      for (int b = 0; b < 7; b++) begin
        for (int r = 0; r < 64; r++) begin
          logic [4:0] x, y, z;
          logic [63:0] p;
          x = 5'(r & 3); y = 5'((r >> 2) & 3); z = 5'((r >> 4) & 3);
          p = {mk(b, z, x, y), mk(a, x, y, z)};
          took = 0;
          for (int k = 0; k < 5 && !took; k++) step(r != 13, p, took);
          if (!took) chk("R4 packet consumed", 32'd0, 32'd1);
        end
      end
    end
    for (int k = 0; k < 3; k++) step(1'b0, 64'd0, took);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule